// File: doc/BRIEF.md
# Protected Page Translation Cache

This block is a small fully associative cache that translates paged logical addresses into physical addresses. A logical address has three parts. The upper bits hold a segment number and then a page number, and together these form the lookup tag. The low bits are the offset inside a 1 KB page. The tag is compared, together with a process ID, against every stored entry at once. On a hit, the stored frame number is joined to the unchanged offset to form the physical address.

Each entry holds a valid flag and three permission bits. An access that matches an entry whose permissions forbid the access kind raises a fault and returns no address. When no entry matches, the block reports a miss in the same cycle. An external page-table walker then supplies the mapping through the refill port. A refill is written on the clock edge where it is presented.

A refill picks its slot in this order:
- an entry that already holds the same key;
- otherwise the lowest-numbered free entry;
- otherwise the entry named by a round-robin pointer.

A flush input empties the whole cache in one cycle. A targeted invalidate removes only the entries whose process ID and tag match.

Top module: `tlb_xlate`

## Requirements
- R1: The request address is 34 bits. Bits [33:16] are the segment number, bits [15:10] the page number, and bits [9:0] the offset. The 24-bit tag is bits [33:10]. On a hit, `paddr_o` is the 14-bit frame in bits [23:10] with the request offset in bits [9:0].
- R2: A request matches an entry only when the entry is valid and both its process ID and its tag are equal to the request's. The result is produced combinationally in the cycle of the request.
- R3: The permission bits are bit 0 read, bit 1 write and bit 2 execute. The access code is 0 read, 1 write, 2 execute; code 3 is never permitted. A match whose permission bit for the access is clear raises `fault_o` instead of `hit_o`.
- R4: While `req_valid_i` is high, exactly one of `hit_o`, `miss_o` and `fault_o` is high. While it is low, all three are low. `paddr_o` is zero unless `hit_o` is high.
- R5: A refill is written on the rising edge where `refill_valid_i` is high. A lookup of that key hits from the next cycle on.
- R6: A refill whose process ID and tag are already held overwrites that entry. It does not take a second slot and does not move the replacement pointer.
- R7: A refill for a new key, when some entry is free, is written into the lowest-numbered free entry.
- R8: A refill for a new key, when all 16 entries are valid, replaces the entry named by a 4-bit pointer. The pointer is 0 after reset, advances by one after each such replacement, and wraps.
- R9: `flush_i` clears every valid flag on one edge. A refill or invalidate presented on that same edge has no effect.
- R10: An invalidate clears only the entries matching both its process ID and its tag. A refill on the same edge is chosen from the state before the edge and is applied after the clear.
- R11: After reset, the cache is empty and every request misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request present |
| req_pid_i | input | 8 | Process ID of the request |
| req_vaddr_i | input | 34 | Logical address (segment, page, offset) |
| req_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| hit_o | output | 1 | Permitted match |
| miss_o | output | 1 | No matching entry; refill wanted |
| fault_o | output | 1 | Match whose permissions forbid the access |
| paddr_o | output | 24 | Physical address, valid with hit_o |
| refill_valid_i | input | 1 | Write a mapping from the walker |
| refill_pid_i | input | 8 | Process ID of the mapping |
| refill_tag_i | input | 24 | Segment and page tag of the mapping |
| refill_frame_i | input | 14 | Frame number |
| refill_perm_i | input | 3 | Permission bits (R, W, X) |
| flush_i | input | 1 | Clear all entries |
| inval_valid_i | input | 1 | Clear entries matching the key below |
| inval_pid_i | input | 8 | Process ID to invalidate |
| inval_tag_i | input | 24 | Tag to invalidate |

## Verification
The bench builds the block with its default parameters. These are 16 entries, an 8-bit process ID, an 18-bit segment number, a 6-bit page number, a 10-bit offset and a 14-bit frame. With only 16 entries, the full state and a complete wrap of the replacement pointer are reached in a few dozen refills. This lets the directed phase prove the exact slot each eviction picks. The random phase then draws keys from a pool only slightly larger than the cache, so hits, overwrites of existing keys, evictions and invalidates all occur often against the bench's reference model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;

  function automatic logic perm_allows(logic [2:0] perm, logic [1:0] acc);
    unique case (acc)
      ACC_READ:  return perm[PERM_R];
      ACC_WRITE: return perm[PERM_W];
      ACC_EXEC:  return perm[PERM_X];
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int N     = 16,
  parameter int KEY_W = 32
) (
  input  logic [N-1:0]            valid_i,
  input  logic [N-1:0][KEY_W-1:0] keys_i,
  input  logic [KEY_W-1:0]        key_i,
  output logic [N-1:0]            match_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (keys_i[g] == key_i);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N     = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         refill_i,
  input  logic [N-1:0] valid_i,
  input  logic [N-1:0] same_i,
  output logic [N-1:0] sel_o,
  output logic [IDX_W-1:0] ptr_o
);
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] same_idx, free_idx;
  logic             use_ptr;

  always_comb begin
    same_idx = '0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (same_i[i])   same_idx = IDX_W'(i);
      if (!valid_i[i]) free_idx = IDX_W'(i);
    end
  end

  assign use_ptr = !(|same_i) && (&valid_i);

  always_comb begin
    sel_o = '0;
    if (|same_i)       sel_o[same_idx] = 1'b1;
    else if (!use_ptr) sel_o[free_idx] = 1'b1;
    else               sel_o[ptr_q]    = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  ptr_q <= '0;
    else if (refill_i && use_ptr) ptr_q <= ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PID_W   = 8,
  parameter int SEG_W   = 18,
  parameter int PAGE_W  = 6,
  parameter int OFF_W   = 10,
  parameter int FRAME_W = 14,
  localparam int TAG_W  = SEG_W + PAGE_W,
  localparam int VA_W   = TAG_W + OFF_W,
  localparam int PA_W   = FRAME_W + OFF_W,
  localparam int KEY_W  = PID_W + TAG_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [PID_W-1:0]   req_pid_i,
  input  logic [VA_W-1:0]    req_vaddr_i,
  input  logic [1:0]         req_acc_i,
  output logic               hit_o,
  output logic               miss_o,
  output logic               fault_o,
  output logic [PA_W-1:0]    paddr_o,
  input  logic               refill_valid_i,
  input  logic [PID_W-1:0]   refill_pid_i,
  input  logic [TAG_W-1:0]   refill_tag_i,
  input  logic [FRAME_W-1:0] refill_frame_i,
  input  logic [2:0]         refill_perm_i,
  input  logic               flush_i,
  input  logic               inval_valid_i,
  input  logic [PID_W-1:0]   inval_pid_i,
  input  logic [TAG_W-1:0]   inval_tag_i
);
  logic [ENTRIES-1:0]              ent_v;
  logic [ENTRIES-1:0][KEY_W-1:0]   ent_key;
  logic [ENTRIES-1:0][FRAME_W-1:0] ent_frame;
  logic [ENTRIES-1:0][2:0]         ent_perm;

  logic [ENTRIES-1:0] req_match, ref_match, inv_match, ref_sel;
  logic [IDX_W-1:0]   rr_ptr;
  logic               refill_go;
  logic [KEY_W-1:0]   req_key, ref_key, inv_key;

  assign req_key   = {req_pid_i, req_vaddr_i[VA_W-1:OFF_W]};
  assign ref_key   = {refill_pid_i, refill_tag_i};
  assign inv_key   = {inval_pid_i, inval_tag_i};
  assign refill_go = refill_valid_i && !flush_i;

  tlb_cam #(.N(ENTRIES), .KEY_W(KEY_W)) u_cam_req (
    .valid_i(ent_v), .keys_i(ent_key), .key_i(req_key), .match_o(req_match)
  );
  tlb_cam #(.N(ENTRIES), .KEY_W(KEY_W)) u_cam_ref (
    .valid_i(ent_v), .keys_i(ent_key), .key_i(ref_key), .match_o(ref_match)
  );
  tlb_cam #(.N(ENTRIES), .KEY_W(KEY_W)) u_cam_inv (
    .valid_i(ent_v), .keys_i(ent_key), .key_i(inv_key), .match_o(inv_match)
  );

  tlb_victim #(.N(ENTRIES)) u_victim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .refill_i(refill_go),
    .valid_i (ent_v),
    .same_i  (ref_match),
    .sel_o   (ref_sel),
    .ptr_o   (rr_ptr)
  );

  // Refill never creates a duplicate key, so req_match is at most one-hot.
  logic [FRAME_W-1:0] hit_frame;
  logic [2:0]         hit_perm;
  logic               any_match, allowed;

  always_comb begin
    hit_frame = '0;
    hit_perm  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      hit_frame |= ent_frame[i] & {FRAME_W{req_match[i]}};
      hit_perm  |= ent_perm[i]  & {3{req_match[i]}};
    end
  end

  assign any_match = |req_match;
  assign allowed   = perm_allows(hit_perm, req_acc_i);
  assign hit_o     = req_valid_i &&  any_match &&  allowed;
  assign fault_o   = req_valid_i &&  any_match && !allowed;
  assign miss_o    = req_valid_i && !any_match;
  assign paddr_o   = hit_o ? {hit_frame, req_vaddr_i[OFF_W-1:0]} : '0;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_v[g]     <= 1'b0;
        ent_key[g]   <= '0;
        ent_frame[g] <= '0;
        ent_perm[g]  <= '0;
      end else if (flush_i) begin
        ent_v[g] <= 1'b0;
      end else begin
        if (inval_valid_i && inv_match[g]) ent_v[g] <= 1'b0;
        if (refill_go && ref_sel[g]) begin
          ent_v[g]     <= 1'b1;
          ent_key[g]   <= ref_key;
          ent_frame[g] <= refill_frame_i;
          ent_perm[g]  <= refill_perm_i;
        end
      end
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int PID_W = 8,
  parameter int TAG_W = 24,
  parameter int VA_W  = 34,
  parameter int PA_W  = 24,
  parameter int OFF_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [PID_W-1:0] req_pid_i,
  input logic [VA_W-1:0]  req_vaddr_i,
  input logic             hit_o,
  input logic             miss_o,
  input logic             fault_o,
  input logic [PA_W-1:0]  paddr_o,
  input logic             refill_valid_i,
  input logic [PID_W-1:0] refill_pid_i,
  input logic [TAG_W-1:0] refill_tag_i,
  input logic             flush_i,
  input logic             inval_valid_i
);
  p_one_result_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> $countones({hit_o, miss_o, fault_o}) == 1);

  p_quiet_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !hit_o && !miss_o && !fault_o && paddr_o == '0);

  p_offset_pass_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> paddr_o[OFF_W-1:0] == req_vaddr_i[OFF_W-1:0]);

  p_flush_empties_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !hit_o && !fault_o);

  p_refill_visible_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refill_valid_i && !flush_i && !inval_valid_i) |=>
      !(req_valid_i && miss_o && req_pid_i == $past(refill_pid_i)
        && req_vaddr_i[VA_W-1:OFF_W] == $past(refill_tag_i)));
endmodule

bind tlb_xlate tlb_xlate_chk #(
  .PID_W(PID_W), .TAG_W(TAG_W), .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_pid_i(req_pid_i), .req_vaddr_i(req_vaddr_i), .hit_o(hit_o),
  .miss_o(miss_o), .fault_o(fault_o), .paddr_o(paddr_o),
  .refill_valid_i(refill_valid_i), .refill_pid_i(refill_pid_i),
  .refill_tag_i(refill_tag_i), .flush_i(flush_i), .inval_valid_i(inval_valid_i)
);

// File: tb/tlb_xlate_bench.sv
module tlb_xlate_bench;
  localparam int N = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [7:0]  req_pid_i = '0;
  logic [33:0] req_vaddr_i = '0;
  logic [1:0]  req_acc_i = '0;
  logic        hit_o, miss_o, fault_o;
  logic [23:0] paddr_o;
  logic        refill_valid_i = 1'b0;
  logic [7:0]  refill_pid_i = '0;
  logic [23:0] refill_tag_i = '0;
  logic [13:0] refill_frame_i = '0;
  logic [2:0]  refill_perm_i = '0;
  logic        flush_i = 1'b0;
  logic        inval_valid_i = 1'b0;
  logic [7:0]  inval_pid_i = '0;
  logic [23:0] inval_tag_i = '0;

  int checks = 0;
  int fails  = 0;

  always #2 clk_i = ~clk_i;

  tlb_xlate u_tlb_xlate (.*);

  // reference model
  bit          m_v[N];
  logic [7:0]  m_pid[N];
  logic [23:0] m_tag[N];
  logic [13:0] m_fr[N];
  logic [2:0]  m_pm[N];
  int          m_ptr;

  task automatic chk(bit ok, string rq, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic bit allows(logic [2:0] pm, logic [1:0] acc);
    if (acc == 2'd3) return 1'b0;
    return pm[acc];
  endfunction

  task automatic model_edge(bit rf, logic [7:0] rp, logic [23:0] rt, logic [13:0] fr,
                            logic [2:0] pm, bit fl, bit iv, logic [7:0] ip, logic [23:0] it);
    int sel;
    bit full;
    if (fl) begin
      for (int i = 0; i < N; i++) m_v[i] = 1'b0;
      return;
    end
    sel = -1;
    full = 1'b1;
    for (int i = 0; i < N; i++)
      if (sel < 0 && m_v[i] && m_pid[i] == rp && m_tag[i] == rt) sel = i;
    if (sel < 0)
      for (int i = 0; i < N; i++)
        if (!m_v[i]) begin
          full = 1'b0;
          if (sel < 0) sel = i;
        end
    if (sel < 0 && full) begin
      sel = m_ptr;
      if (rf) m_ptr = (m_ptr + 1) % N;
    end
    if (iv)
      for (int i = 0; i < N; i++)
        if (m_v[i] && m_pid[i] == ip && m_tag[i] == it) m_v[i] = 1'b0;
    if (rf) begin
      m_v[sel] = 1'b1; m_pid[sel] = rp; m_tag[sel] = rt;
      m_fr[sel] = fr;  m_pm[sel] = pm;
    end
  endtask

  // one clock edge with the given maintenance inputs
  task automatic step(bit rf, logic [7:0] rp, logic [23:0] rt, logic [13:0] fr,
                      logic [2:0] pm, bit fl, bit iv, logic [7:0] ip, logic [23:0] it);
    refill_valid_i = rf; refill_pid_i = rp; refill_tag_i = rt;
    refill_frame_i = fr; refill_perm_i = pm;
    flush_i = fl; inval_valid_i = iv; inval_pid_i = ip; inval_tag_i = it;
    @(posedge clk_i);
    model_edge(rf, rp, rt, fr, pm, fl, iv, ip, it);
    @(negedge clk_i);
    refill_valid_i = 1'b0; flush_i = 1'b0; inval_valid_i = 1'b0;
  endtask

  task automatic refill(logic [7:0] p, logic [23:0] t, logic [13:0] f, logic [2:0] pm);
    step(1'b1, p, t, f, pm, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic look(logic [7:0] p, logic [23:0] t, logic [9:0] off,
                      logic [1:0] acc, string rq);
    logic [2:0]  e_res;
    logic [23:0] e_pa;
    int          idx;
    req_valid_i = 1'b1; req_pid_i = p; req_vaddr_i = {t, off}; req_acc_i = acc;
    #1;
    idx = -1;
    for (int i = 0; i < N; i++)
      if (idx < 0 && m_v[i] && m_pid[i] == p && m_tag[i] == t) idx = i;
    if (idx < 0) begin
      e_res = 3'b010; e_pa = '0;
    end else if (allows(m_pm[idx], acc)) begin
      e_res = 3'b100; e_pa = {m_fr[idx], off};
    end else begin
      e_res = 3'b001; e_pa = '0;
    end
    chk({hit_o, miss_o, fault_o} == e_res && paddr_o == e_pa, rq,
        {37'd0, hit_o, miss_o, fault_o, paddr_o}, {37'd0, e_res, e_pa});
    req_valid_i = 1'b0;
    #1;
  endtask

  function automatic logic [23:0] tg(int i);
    return {18'(i + 1), 6'(i * 5)};
  endfunction

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    m_ptr = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R11: empty after reset
    look(8'd1, tg(0), 10'h3ff, 2'd0, "R11");
    look(8'd0, 24'd0, 10'h0, 2'd0, "R11");

    // R4: idle request drives nothing
    req_valid_i = 1'b0; #1;
    chk(!hit_o && !miss_o && !fault_o && paddr_o == 0, "R4",
        {hit_o, miss_o, fault_o}, 0);

    // R5 R7: fill in order, each visible after its edge
    for (int i = 0; i < N; i++) begin
      refill(8'd1, tg(i), 14'(100 + i), 3'b111);
      look(8'd1, tg(i), 10'(i * 37), 2'd0, "R5");
    end
    for (int i = 0; i < N; i++) look(8'd1, tg(i), 10'h2a5, 2'(i % 3), "R1 R7");

    // R2: same tag, other process misses
    look(8'd2, tg(3), 10'h1, 2'd0, "R2");

    // R6 R3: overwrite entry 4 with read-only permissions
    refill(8'd1, tg(4), 14'h3abc, 3'b001);
    look(8'd1, tg(4), 10'h155, 2'd0, "R6");
    look(8'd1, tg(4), 10'h155, 2'd1, "R3");
    look(8'd1, tg(4), 10'h155, 2'd2, "R3");
    look(8'd1, tg(4), 10'h155, 2'd3, "R3");
    refill(8'd1, tg(6), 14'h0042, 3'b100);
    look(8'd1, tg(6), 10'h3, 2'd2, "R3");
    look(8'd1, tg(6), 10'h3, 2'd0, "R3");

    // R8: full, round-robin from slot 0 (overwrites above did not move it)
    refill(8'd3, tg(40), 14'h111, 3'b111);
    look(8'd1, tg(0), 10'h0, 2'd0, "R8");
    look(8'd1, tg(1), 10'h0, 2'd0, "R8");
    refill(8'd3, tg(41), 14'h222, 3'b111);
    look(8'd1, tg(1), 10'h0, 2'd0, "R8");
    look(8'd3, tg(41), 10'h7, 2'd1, "R8");

    // R10: targeted invalidate, then refill lands in the freed slot
    step(1'b0, '0, '0, '0, '0, 1'b0, 1'b1, 8'd1, tg(9));
    look(8'd1, tg(9), 10'h0, 2'd0, "R10");
    look(8'd1, tg(10), 10'h0, 2'd0, "R10");
    refill(8'd3, tg(42), 14'h333, 3'b111);
    look(8'd1, tg(8), 10'h0, 2'd0, "R7");
    refill(8'd3, tg(43), 14'h444, 3'b111);
    look(8'd1, tg(2), 10'h0, 2'd0, "R8");
    look(8'd1, tg(3), 10'h0, 2'd0, "R8");

    // R9: flush wins over a same-edge refill
    step(1'b1, 8'd5, tg(50), 14'h555, 3'b111, 1'b1, 1'b0, '0, '0);
    look(8'd5, tg(50), 10'h0, 2'd0, "R9");
    for (int i = 0; i < N; i++) look(8'd1, tg(i), 10'h0, 2'd0, "R9");

    // random mix against the model
    for (int n = 0; n < 1500; n++) begin
      int op;
      logic [7:0]  p;
      logic [23:0] t;
      op = int'($urandom % 100);
      p  = 8'($urandom % 2);
      t  = tg(int'($urandom % 12));
      if (op < 40)
        refill(p, t, 14'($urandom), 3'($urandom));
      else if (op < 50)
        step(1'b0, '0, '0, '0, '0, 1'b0, 1'b1, p, t);
      else if (op < 56)
        step(1'b1, 8'($urandom % 2), tg(int'($urandom % 12)), 14'($urandom),
             3'($urandom), 1'b0, 1'b1, p, t);
      else if (op < 58)
        step(1'b0, '0, '0, '0, '0, 1'b1, 1'b0, '0, '0);
      look(8'($urandom % 2), tg(int'($urandom % 12)), 10'($urandom),
           2'($urandom), "R2 R3 R6 R10");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule